// File: doc/BRIEF.md
# Simultaneous-Hold Conversion Scheduler

This block arbitrates between three channel pairs that share one converter. Each pair has an active-low hold strobe. A falling edge on a strobe freezes that pair's two input samples and queues the pair for conversion. The pairs in the queue then run one after another through a fixed-length conversion frame. During the early part of each frame the active-low busy flag is driven low.

Part-way through the frame the block issues a single-cycle write strobe to downstream storage. The strobe carries two tagged 12-bit results, one for input 0 and one for input 1 of the pair. A stall input can hold that write back. The analog converter is modelled as a data source of fixed latency. It returns the values captured at the hold edge.

Reset cancels everything: the running frame, the queue and the captured samples.

Top module: `hs_sched`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_no` is 1 and `wr_o` is 0. A reset during a frame cancels that frame and every queued pair, so no write follows for them.
- R2: A pair is detected at the rising edge where its hold line is sampled low after having been sampled high. If the converter is idle, `busy_no` goes low after the next rising edge.
- R3: `busy_no` stays low for 13 cycles (with no stall). At the edge where it returns high, `wr_o` pulses for exactly one cycle.
- R4: The write carries tags `2*p` on the low result and `2*p+1` on the high result: A0=000, A1=001, B0=010, B1=011, C0=100, C1=101. Pair A is hold bit 0, B is bit 1 and C is bit 2. The data are the `samp_i` slices `[(2p+i)*12 +: 12]` captured at the detection edge.
- R5: Pairs detected at the same edge are converted in the order A, then B, then C.
- R6: A pair detected while others are queued or converting waits behind them in order of detection.
- R7: Back-to-back frames are 16 cycles apart. Consecutive writes of queued pairs are therefore 16 cycles apart.
- R8: A repeat hold on a pair that is queued or converting has no effect. A hold line that stays low starts only one conversion. A line that is low when reset is released is not detected until it has been seen high.
- R9: While `stall_i` is high at the latch point, the write is withheld and `busy_no` stays low. The write is issued at the first edge where `stall_i` is sampled low.
- R10: Once a pair's frame has ended, a new hold on that pair is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 3 | Active-low hold strobes, bit 0 = pair A, bit 2 = pair C |
| samp_i | input | 72 | Analog sample model, six 12-bit slices |
| stall_i | input | 1 | Downstream stall, holds back the write |
| busy_no | output | 1 | Active-low busy flag |
| wr_o | output | 1 | Single-cycle result write strobe |
| wr_tag_lo_o | output | 3 | Channel tag of input 0 result |
| wr_dat_lo_o | output | 12 | Input 0 result |
| wr_tag_hi_o | output | 3 | Channel tag of input 1 result |
| wr_dat_hi_o | output | 12 | Input 1 result |

## Verification
A single isolated hold shows the detection latency, the busy window and the write cycle. Three strobes falling together, and a staggered pattern of B first then A with C, separate the fixed priority from the arrival order. The second pattern also changes the samples between detections, which shows that each pair keeps its own captured values. A repeat pulse, a hold left low, a stalled latch, and a reset both mid-frame and with a hold already low cover the cases where an input must not start or finish a conversion.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int TAG_W = 3;
    localparam int PW    = TAG_W - 1;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_TAIL
    } phase_e;

    // channel tag: pair index in the upper bits, input select in bit 0
    function automatic tag_t chan_tag(input logic [PW-1:0] pair, input logic upper);
        return {pair, upper};
    endfunction

endpackage

// File: rtl/hs_hold_edge.sv
module hs_hold_edge #(
    parameter int NP = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NP-1:0] hold_ni,
    input  logic [NP-1:0] pend_i,
    output logic [NP-1:0] det_o
);

    typedef struct packed {
        logic [NP-1:0] seen_hi;
    } edge_t;

    edge_t cur_q, nxt_d;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.seen_hi = hold_ni;
        det_o         = cur_q.seen_hi & ~hold_ni & ~pend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.seen_hi <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R8
    seen_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (det_o & ~$past(hold_ni)) == '0)
        else $error("detection without prior high level");

endmodule

// File: rtl/hs_order_q.sv
module hs_order_q #(
    parameter int NP = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NP-1:0] push_i,
    input  logic          pop_i,
    output logic          vld_o,
    output logic [((NP > 1) ? $clog2(NP) : 1)-1:0] head_o,
    output logic [$clog2(NP+1)-1:0] cnt_o
);

    localparam int IW = (NP > 1) ? $clog2(NP) : 1;
    localparam int CW = $clog2(NP + 1);

    typedef struct packed {
        logic [NP-1:0][IW-1:0] ent;
        logic [CW-1:0]         cnt;
    } oq_t;

    oq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (pop_i && (cur_q.cnt != '0)) begin
            for (int i = 0; i < NP - 1; i++) begin
                nxt_d.ent[i] = cur_q.ent[i+1];
            end
            nxt_d.ent[NP-1] = '0;
            nxt_d.cnt       = cur_q.cnt - 1'b1;
        end
        // lower index first: fixed priority among same-cycle arrivals
        for (int p = 0; p < NP; p++) begin
            if (push_i[p] && (nxt_d.cnt < CW'(NP))) begin
                nxt_d.ent[IW'(nxt_d.cnt)] = IW'(p);
                nxt_d.cnt                 = nxt_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign vld_o  = (cur_q.cnt != '0);
    assign head_o = cur_q.ent[0];
    assign cnt_o  = cur_q.cnt;

    // R6
    depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.cnt <= CW'(NP))
        else $error("queue depth exceeded");

    // R6
    pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (cur_q.cnt != '0))
        else $error("pop from empty queue");

endmodule

// File: rtl/hs_conv_model.sv
module hs_conv_model #(
    parameter int NP = 3,
    parameter int DW = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NP-1:0]      cap_i,
    input  logic [NP*2*DW-1:0] samp_i,
    input  logic [((NP > 1) ? $clog2(NP) : 1)-1:0] sel_i,
    output logic [DW-1:0]      lo_o,
    output logic [DW-1:0]      hi_o
);

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } pair_smp_t;

    pair_smp_t [NP-1:0] smp_q;
    pair_smp_t [NP-1:0] smp_d;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        always_comb begin
            smp_d[p] = smp_q[p];
            if (cap_i[p]) begin
                smp_d[p].lo = samp_i[(2*p)*DW +: DW];
                smp_d[p].hi = samp_i[(2*p+1)*DW +: DW];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                smp_q[p] <= '0;
            end else begin
                smp_q[p] <= smp_d[p];
            end
        end
    end

    always_comb begin
        lo_o = '0;
        hi_o = '0;
        for (int p = 0; p < NP; p++) begin
            if (sel_i == $bits(sel_i)'(p)) begin
                lo_o = smp_q[p].lo;
                hi_o = smp_q[p].hi;
            end
        end
    end

endmodule

// File: rtl/hs_sched.sv
module hs_sched
    import hs_pkg::*;
#(
    parameter int NPAIR     = 3,
    parameter int DW        = 12,
    parameter int FRAME_LEN = 16,
    parameter int LATCH_AT  = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NPAIR-1:0]      hold_ni,
    input  logic [NPAIR*2*DW-1:0] samp_i,
    input  logic                  stall_i,
    output logic                  busy_no,
    output logic                  wr_o,
    output logic [TAG_W-1:0]      wr_tag_lo_o,
    output logic [DW-1:0]         wr_dat_lo_o,
    output logic [TAG_W-1:0]      wr_tag_hi_o,
    output logic [DW-1:0]         wr_dat_hi_o
);

    localparam int IW = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam int CW = $clog2(FRAME_LEN);
    localparam int QW = $clog2(NPAIR + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CW-1:0]    cnt;
        logic [IW-1:0]    act;
        logic [NPAIR-1:0] pend;
        logic             busy_n;
        logic             wr;
        tag_t             tag_lo;
        tag_t             tag_hi;
        logic [DW-1:0]    d_lo;
        logic [DW-1:0]    d_hi;
    } sch_t;

    sch_t cur_q, nxt_d;

    logic [NPAIR-1:0] det;
    logic             q_vld;
    logic [IW-1:0]    q_head;
    logic [QW-1:0]    q_cnt;
    logic             pop;
    logic             start;
    logic [DW-1:0]    m_lo;
    logic [DW-1:0]    m_hi;

    hs_hold_edge #(.NP(NPAIR)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_ni (hold_ni),
        .pend_i  (cur_q.pend),
        .det_o   (det)
    );

    hs_order_q #(.NP(NPAIR)) u_queue (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (det),
        .pop_i  (pop),
        .vld_o  (q_vld),
        .head_o (q_head),
        .cnt_o  (q_cnt)
    );

    hs_conv_model #(.NP(NPAIR), .DW(DW)) u_model (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cap_i  (det),
        .samp_i (samp_i),
        .sel_i  (cur_q.act),
        .lo_o   (m_lo),
        .hi_o   (m_hi)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.wr   = 1'b0;
        nxt_d.pend = cur_q.pend | det;
        start      = 1'b0;
        pop        = 1'b0;

        unique case (cur_q.ph)
            PH_IDLE: begin
                start = q_vld;
            end
            PH_RUN: begin
                if (cur_q.cnt == CW'(LATCH_AT)) begin
                    if (!stall_i) begin
                        nxt_d.wr     = 1'b1;
                        nxt_d.busy_n = 1'b1;
                        nxt_d.tag_lo = chan_tag(PW'(cur_q.act), 1'b0);
                        nxt_d.tag_hi = chan_tag(PW'(cur_q.act), 1'b1);
                        nxt_d.d_lo   = m_lo;
                        nxt_d.d_hi   = m_hi;
                        nxt_d.cnt    = cur_q.cnt + 1'b1;
                        nxt_d.ph     = PH_TAIL;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            PH_TAIL: begin
                if (cur_q.cnt == CW'(FRAME_LEN - 1)) begin
                    nxt_d.pend[cur_q.act] = 1'b0;
                    nxt_d.ph              = PH_IDLE;
                    start                 = q_vld;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d.ph = PH_IDLE;
            end
        endcase

        if (start) begin
            pop          = 1'b1;
            nxt_d.ph     = PH_RUN;
            nxt_d.act    = q_head;
            nxt_d.cnt    = '0;
            nxt_d.busy_n = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q        <= '0;
            cur_q.ph     <= PH_IDLE;
            cur_q.busy_n <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_no     = cur_q.busy_n;
    assign wr_o        = cur_q.wr;
    assign wr_tag_lo_o = cur_q.tag_lo;
    assign wr_tag_hi_o = cur_q.tag_hi;
    assign wr_dat_lo_o = cur_q.d_lo;
    assign wr_dat_hi_o = cur_q.d_hi;

    // R3
    wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |=> !wr_o)
        else $error("write strobe longer than one cycle");

    // R3
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_no) |-> wr_o)
        else $error("busy released without a write");

    // R9
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |-> !$past(stall_i))
        else $error("write issued under stall");

    // R4
    tag_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |-> (!wr_tag_lo_o[0] && (wr_tag_hi_o == wr_tag_lo_o + 1'b1)))
        else $error("write tags not a pair");

    // R8
    pend_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(cur_q.pend) == (int'(q_cnt) + ((cur_q.ph != PH_IDLE) ? 1 : 0)))
        else $error("pending set disagrees with queue and active slot");

endmodule

// File: tb/sim_hs_sched.sv
module sim_hs_sched;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  hold_n;
    logic [71:0] samp;
    logic        stall;
    logic        busy_n, wr;
    logic [2:0]  tag_lo, tag_hi;
    logic [11:0] dat_lo, dat_hi;

    int checks = 0;
    int errors = 0;
    int nwr = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [26:0] exp_q[$];
    int          wr_times[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_sched u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hold_ni     (hold_n),
        .samp_i      (samp),
        .stall_i     (stall),
        .busy_no     (busy_n),
        .wr_o        (wr),
        .wr_tag_lo_o (tag_lo),
        .wr_dat_lo_o (dat_lo),
        .wr_tag_hi_o (tag_hi),
        .wr_dat_hi_o (dat_hi)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] mkv(input logic [11:0] seed);
        logic [71:0] v;
        for (int k = 0; k < 6; k++) v[k*DW +: DW] = seed + 12'(k * 12'h111);
        return v;
    endfunction

    // driver side of the scoreboard: expected write for pair p from sample vector v
    task automatic expect_pair(input int p, input logic [71:0] v);
        exp_q.push_back({3'(2*p), v[(2*p)*DW +: DW], v[(2*p+1)*DW +: DW]});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every write (R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n && wr && !done) begin
            nwr++;
            wr_times.push_back(cyc);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", {29'd0, tag_lo}, 32'hFFFF);
            end else begin
                logic [26:0] e;
                e = exp_q.pop_front();
                chk({tag_lo, dat_lo, dat_hi} == e, "R4/R5/R6 write tag+data order",
                    {5'd0, tag_lo, dat_lo, dat_hi}, {5'd0, e});
                chk(tag_hi == e[26:24] + 3'd1, "R4 upper tag", {29'd0, tag_hi},
                    {29'd0, e[26:24] + 3'd1});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [71:0] v;
        rst_n = 1'b0; hold_n = 3'b111; samp = '0; stall = 1'b0;
        tick(3);
        chk(busy_n === 1'b1, "R1 busy in reset", {31'd0, busy_n}, 1);
        chk(wr === 1'b0, "R1 write in reset", {31'd0, wr}, 0);
        rst_n = 1'b1;
        tick(2);
        chk(busy_n === 1'b1 && wr === 1'b0, "R1 idle after reset", {30'd0, busy_n, wr}, 2);

        // single hold on pair A
        v = mkv(12'h3A5); samp = v; hold_n = 3'b110; expect_pair(0, v);
        tick(1);
        chk(busy_n === 1'b1, "R2 busy high one cycle after hold", {31'd0, busy_n}, 1);
        hold_n = 3'b111;
        tick(1);
        chk(busy_n === 1'b0, "R2 busy low after start edge", {31'd0, busy_n}, 0);
        tick(12);
        chk(busy_n === 1'b0 && wr === 1'b0, "R3 busy still low in 13th cycle", {30'd0, busy_n, wr}, 0);
        tick(1);
        chk(busy_n === 1'b1 && wr === 1'b1, "R3 write with busy release", {30'd0, busy_n, wr}, 3);
        tick(1);
        chk(wr === 1'b0, "R3 write lasts one cycle", {31'd0, wr}, 0);
        tick(6);

        // three holds in the same cycle
        wr_times.delete();
        v = mkv(12'h5C0); samp = v; hold_n = 3'b000;
        expect_pair(0, v); expect_pair(1, v); expect_pair(2, v);
        tick(1);
        hold_n = 3'b111;
        tick(56);
        chk(wr_times.size() == 3, "R5 three writes", wr_times.size(), 3);
        if (wr_times.size() == 3) begin
            chk(wr_times[1] - wr_times[0] == 16, "R7 frame spacing 1", wr_times[1] - wr_times[0], 16);
            chk(wr_times[2] - wr_times[1] == 16, "R7 frame spacing 2", wr_times[2] - wr_times[1], 16);
        end

        // B first, then A and C together with new samples
        v = mkv(12'h111); samp = v; hold_n = 3'b101; expect_pair(1, v);
        tick(1);
        v = mkv(12'h7E3); samp = v; hold_n = 3'b000; expect_pair(0, v); expect_pair(2, v);
        tick(1);
        hold_n = 3'b111;
        tick(56);
        chk(exp_q.size() == 0, "R6 arrival order drained", exp_q.size(), 0);

        // repeat hold while pending
        base = nwr;
        v = mkv(12'h0F0); samp = v; hold_n = 3'b110; expect_pair(0, v);
        tick(1); hold_n = 3'b111;
        tick(5);
        samp = mkv(12'hABC); hold_n = 3'b110;
        tick(1); hold_n = 3'b111;
        tick(20);
        chk(nwr - base == 1, "R8 repeat hold ignored", nwr - base, 1);
        v = mkv(12'h246); samp = v; hold_n = 3'b110; expect_pair(0, v);
        tick(1); hold_n = 3'b111;
        tick(20);
        chk(nwr - base == 2, "R10 hold re-armed after frame", nwr - base, 2);

        // hold left low
        base = nwr;
        v = mkv(12'h9D1); samp = v; hold_n = 3'b011; expect_pair(2, v);
        tick(40);
        hold_n = 3'b111;
        tick(20);
        chk(nwr - base == 1, "R8 held-low line converts once", nwr - base, 1);

        // stall at the latch point
        base = nwr;
        stall = 1'b1;
        v = mkv(12'h4B7); samp = v; hold_n = 3'b110; expect_pair(0, v);
        tick(1); hold_n = 3'b111;
        tick(25);
        chk(busy_n === 1'b0 && nwr == base, "R9 stalled write withheld", {30'd0, busy_n, wr}, 0);
        stall = 1'b0;
        tick(1);
        chk(wr === 1'b1 && busy_n === 1'b1, "R9 write after stall drops", {30'd0, busy_n, wr}, 3);
        tick(10);

        // reset mid-frame, with a hold already low
        base = nwr;
        samp = mkv(12'h777); hold_n = 3'b101;
        tick(1); hold_n = 3'b111;
        tick(5);
        rst_n = 1'b0; hold_n = 3'b110;
        tick(1);
        chk(busy_n === 1'b1, "R1 busy released by reset", {31'd0, busy_n}, 1);
        rst_n = 1'b1;
        tick(20);
        chk(nwr == base && busy_n === 1'b1, "R1 cancelled frame, R8 low at reset", nwr - base, 0);
        hold_n = 3'b111;
        tick(1);
        v = mkv(12'hC3C); samp = v; hold_n = 3'b110; expect_pair(0, v);
        tick(1); hold_n = 3'b111;
        tick(20);
        chk(nwr - base == 1, "R2 detection after reset", nwr - base, 1);
        chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule